// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This unit keeps a small byte queue of upcoming instruction bytes topped up from a 32-bit code bus. It only starts a fetch when the core is not using the bus. Every fetch reads one 4-byte word from a word-aligned address, and the bus cycle lasts a fixed number of unit clocks. The core pulls 1 to 4 bytes at a time from the head of the queue. When the queue is short of what the core asks for, a stall line holds the core until enough bytes have arrived.

A branch flushes the queue, drops any word still in flight, and restarts fetching at the aligned word that contains the target. From that first word only the target byte and the bytes above it are loaded, which gives 4, 3, 2 or 1 bytes. Fetching after that continues with whole words. After reset the unit behaves as if it had branched to the reset vector port.

The read side is a valid/ready port. The core holds `rd_valid` with the byte count in `rd_count`. `rd_ready` is high whenever the queue holds at least that many bytes. A transfer happens on a clock edge where both are high and no branch is presented. While `rd_valid` is high and `rd_ready` is low, the core must keep `rd_count` steady. In that case `stall` is asserted.

Top module: `ifetch_queue`

## Requirements
- R1: After reset the queue is empty: `rd_ready` is low for a request of 1 byte and `bus_req` is low during reset. The first fetch after reset goes to the reset vector with its low 2 bits cleared.
- R2: A fetch holds `bus_req` high for exactly BUS_CYCLES (default 2) clocks and keeps `bus_addr` constant for that time. `bus_addr[1:0]` is always 00. The read word is taken on the last of those clocks. Byte k of the word (bits 8k+7..8k) belongs to address `bus_addr + k`.
- R3: The queue never holds more than DEPTH (default 10) bytes. A fetch starts only when the free space is at least the number of bytes that fetch will load. With 8 of 10 bytes held, a full-word fetch waits until 2 bytes have been consumed.
- R4: No fetch starts while `core_bus_busy` is high. A fetch already in flight when it rises still completes and loads its bytes.
- R5: `rd_ready` is high exactly when the queue holds at least `rd_count` bytes, with `rd_count` in 1..4. On a transfer the oldest `rd_count` bytes leave the queue. `rd_data` byte k (bits 8k+7..8k) is the k-th oldest byte.
- R6: `stall` is high when `rd_valid` is high and `rd_ready` is low. While the core is stalled, no byte leaves the queue.
- R7: A cycle with `branch_valid` high empties the queue by the next cycle and cancels any fetch in flight. The cancelled word is never loaded, and `bus_req` is low in the next cycle.
- R8: After a branch, the first word loads only the target byte and the bytes above it: 4 bytes for target low bits 00, 3 for 01, 2 for 10 and 1 for 11. The target byte becomes `rd_data` byte 0.
- R9: Bytes reach the core in ascending address order, with no gap or repeat. This holds across the partial first word and all later whole words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reset_vector | input | 24 | Byte address of the first instruction after reset |
| branch_valid | input | 1 | Flush the queue and refetch from `branch_target` |
| branch_target | input | 24 | Byte address of the branch destination |
| core_bus_busy | input | 1 | Core owns the internal bus; no fetch may start |
| bus_req | output | 1 | Fetch bus cycle in progress |
| bus_addr | output | 24 | Word-aligned fetch address |
| bus_rdata | input | 32 | Code word returned by memory, lowest address in bits 7..0 |
| rd_valid | input | 1 | Core requests `rd_count` bytes |
| rd_count | input | 3 | Number of bytes requested, 1..4 |
| rd_ready | output | 1 | Queue holds at least `rd_count` bytes |
| rd_data | output | 32 | Four oldest queue bytes, oldest in bits 7..0 |
| stall | output | 1 | Core must wait: request not yet satisfiable |

## Verification
A sequential stream with request sizes cycling from 1 to 4 and gaps in `rd_valid` checks that the head slides correctly for every pop width. Branches to targets with each of the four low-bit patterns check the partial first word: byte 0 must be the target, and readiness must flip exactly at the loaded count. Idling with a full queue, then freeing one byte and then a second, finds the boundary between "too little room" and "room for a word". A branch during the last cycle of a fetch, and raising the bus-busy line both before and during a fetch, separate cancelled words from completed ones.

// File: rtl/ifq_pkg.sv
package ifq_pkg;
  localparam int IFQ_ADDR_W     = 24;
  localparam int IFQ_WORD_BYTES = 4;
  localparam int IFQ_DEPTH      = 10;
  localparam int IFQ_BUS_CYCLES = 2;

  typedef enum logic {
    FETCH_IDLE = 1'b0,
    FETCH_RUN  = 1'b1
  } fetch_state_e;
endpackage

// File: rtl/ifq_align.sv
// Drops the bytes below the branch target from a fetched word and
// reports how many bytes remain.
module ifq_align #(
  parameter int WB = 4
) (
  input  logic [8*WB-1:0]          word_in,
  input  logic [$clog2(WB)-1:0]    skip,
  output logic [8*WB-1:0]          bytes_out,
  output logic [$clog2(WB+1)-1:0]  load_n
);
  localparam int SKIP_W = $clog2(WB);
  localparam int LOAD_W = $clog2(WB+1);

  always_comb begin
    bytes_out = word_in >> {skip, 3'b000};
    load_n    = LOAD_W'(WB) - LOAD_W'(skip);
  end
endmodule

// File: rtl/ifq_fetch_ctrl.sv
// Bus sequencer: decides when a word fetch may start, times the bus
// cycle and advances the word address.
module ifq_fetch_ctrl
  import ifq_pkg::*;
#(
  parameter int ADDR_W     = IFQ_ADDR_W,
  parameter int WB         = IFQ_WORD_BYTES,
  parameter int BUS_CYCLES = IFQ_BUS_CYCLES,
  parameter int CNT_W      = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       reset_vector,
  input  logic                    branch_valid,
  input  logic [ADDR_W-1:0]       branch_target,
  input  logic                    core_bus_busy,
  input  logic [CNT_W-1:0]        free_space,
  output logic                    bus_req,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic                    wr_en,
  output logic [$clog2(WB)-1:0]   wr_skip
);
  localparam int SKIP_W = $clog2(WB);
  localparam int LOAD_W = $clog2(WB+1);
  localparam int PH_W   = (BUS_CYCLES > 1) ? $clog2(BUS_CYCLES) : 1;

  fetch_state_e        state_r;
  logic [PH_W-1:0]     phase_r;
  logic [ADDR_W-1:0]   word_addr_r;
  logic [SKIP_W-1:0]   skip_r;
  logic [LOAD_W-1:0]   next_load;
  logic                start;
  logic                last;

  always_comb begin
    next_load = LOAD_W'(WB) - LOAD_W'(skip_r);
    start     = (state_r == FETCH_IDLE) && !branch_valid && !core_bus_busy &&
                (free_space >= CNT_W'(next_load));
    last      = (state_r == FETCH_RUN) && (phase_r == PH_W'(BUS_CYCLES - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_r     <= FETCH_IDLE;
      phase_r     <= '0;
      word_addr_r <= {reset_vector[ADDR_W-1:SKIP_W], {SKIP_W{1'b0}}};
      skip_r      <= reset_vector[SKIP_W-1:0];
    end else if (branch_valid) begin
      state_r     <= FETCH_IDLE;
      phase_r     <= '0;
      word_addr_r <= {branch_target[ADDR_W-1:SKIP_W], {SKIP_W{1'b0}}};
      skip_r      <= branch_target[SKIP_W-1:0];
    end else if (start) begin
      state_r <= FETCH_RUN;
      phase_r <= '0;
    end else if (last) begin
      state_r     <= FETCH_IDLE;
      word_addr_r <= word_addr_r + ADDR_W'(WB);
      skip_r      <= '0;
    end else if (state_r == FETCH_RUN) begin
      phase_r <= phase_r + 1'b1;
    end
  end

  assign bus_req  = (state_r == FETCH_RUN);
  assign bus_addr = word_addr_r;
  assign wr_en    = last && !branch_valid;
  assign wr_skip  = skip_r;
endmodule

// File: rtl/ifq_byte_queue.sv
// Byte queue kept as a packed shift vector, oldest byte in the low bits.
// Bytes above the fill level are always zero, so a push is a shifted OR.
module ifq_byte_queue #(
  parameter int DEPTH  = 10,
  parameter int WB     = 4,
  parameter int CNT_W  = 4,
  parameter int LOAD_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [LOAD_W-1:0] pop_n,
  input  logic              push_en,
  input  logic [LOAD_W-1:0] push_n,
  input  logic [8*WB-1:0]   push_bytes,
  output logic [CNT_W-1:0]  count,
  output logic [8*WB-1:0]   head
);
  localparam int QBITS = 8 * DEPTH;

  logic [QBITS-1:0] q_r, q_nxt;
  logic [CNT_W-1:0] cnt_r, cnt_nxt, base;

  always_comb begin
    base    = cnt_r - CNT_W'(pop_n);
    q_nxt   = q_r >> {pop_n, 3'b000};
    cnt_nxt = base;
    if (push_en) begin
      q_nxt   = q_nxt | (QBITS'(push_bytes) << {base, 3'b000});
      cnt_nxt = base + CNT_W'(push_n);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      q_r   <= '0;
      cnt_r <= '0;
    end else begin
      q_r   <= q_nxt;
      cnt_r <= cnt_nxt;
    end
  end

  assign count = cnt_r;
  assign head  = q_r[8*WB-1:0];
endmodule

// File: rtl/ifetch_queue.sv
module ifetch_queue
  import ifq_pkg::*;
#(
  parameter int ADDR_W     = IFQ_ADDR_W,
  parameter int WB         = IFQ_WORD_BYTES,
  parameter int DEPTH      = IFQ_DEPTH,
  parameter int BUS_CYCLES = IFQ_BUS_CYCLES
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        reset_vector,
  input  logic                     branch_valid,
  input  logic [ADDR_W-1:0]        branch_target,
  input  logic                     core_bus_busy,
  output logic                     bus_req,
  output logic [ADDR_W-1:0]        bus_addr,
  input  logic [8*WB-1:0]          bus_rdata,
  input  logic                     rd_valid,
  input  logic [$clog2(WB+1)-1:0]  rd_count,
  output logic                     rd_ready,
  output logic [8*WB-1:0]          rd_data,
  output logic                     stall
);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int LOAD_W = $clog2(WB + 1);
  localparam int SKIP_W = $clog2(WB);

  logic [CNT_W-1:0]  q_count;
  logic [CNT_W-1:0]  free_space;
  logic [LOAD_W-1:0] pop_n;
  logic              wr_en;
  logic [SKIP_W-1:0] wr_skip;
  logic [8*WB-1:0]   al_bytes;
  logic [LOAD_W-1:0] al_n;

  always_comb begin
    free_space = CNT_W'(DEPTH) - q_count;
    rd_ready   = CNT_W'(rd_count) <= q_count;
    stall      = rd_valid && !rd_ready;
    pop_n      = (rd_valid && rd_ready && !branch_valid) ? rd_count : '0;
  end

  ifq_fetch_ctrl #(
    .ADDR_W(ADDR_W), .WB(WB), .BUS_CYCLES(BUS_CYCLES), .CNT_W(CNT_W)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .reset_vector(reset_vector),
    .branch_valid(branch_valid), .branch_target(branch_target),
    .core_bus_busy(core_bus_busy), .free_space(free_space),
    .bus_req(bus_req), .bus_addr(bus_addr),
    .wr_en(wr_en), .wr_skip(wr_skip)
  );

  ifq_align #(.WB(WB)) u_align (
    .word_in(bus_rdata), .skip(wr_skip),
    .bytes_out(al_bytes), .load_n(al_n)
  );

  ifq_byte_queue #(
    .DEPTH(DEPTH), .WB(WB), .CNT_W(CNT_W), .LOAD_W(LOAD_W)
  ) u_queue (
    .clk(clk), .rst_n(rst_n), .flush(branch_valid),
    .pop_n(pop_n), .push_en(wr_en), .push_n(al_n), .push_bytes(al_bytes),
    .count(q_count), .head(rd_data)
  );
endmodule

// File: rtl/ifq_checker.sv
module ifq_checker #(
  parameter int ADDR_W = 24,
  parameter int WB     = 4,
  parameter int DEPTH  = 10,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              branch_valid,
  input logic              core_bus_busy,
  input logic              bus_req,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [CNT_W-1:0]  q_count
);
  localparam int SKIP_W = $clog2(WB);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CNT_W'(DEPTH));

  a_r2_aligned_addr: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_addr[SKIP_W-1:0] == '0);

  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !branch_valid |=> !bus_req || $stable(bus_addr));

  a_r4_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req && core_bus_busy |=> !bus_req);

  a_r7_flush: assert property (@(posedge clk) disable iff (!rst_n)
    branch_valid |=> q_count == '0 && !bus_req);

  a_r6_stall_holds_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !branch_valid |=> q_count >= $past(q_count));
endmodule

bind ifetch_queue ifq_checker #(
  .ADDR_W(ADDR_W), .WB(WB), .DEPTH(DEPTH), .CNT_W($clog2(DEPTH + 1))
) u_ifq_chk (
  .clk(clk), .rst_n(rst_n), .branch_valid(branch_valid),
  .core_bus_busy(core_bus_busy), .bus_req(bus_req), .bus_addr(bus_addr),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .q_count(q_count)
);

// File: tb/test_ifetch_queue.sv
module test_ifetch_queue;
  localparam int AW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0] reset_vector = 24'h001000;
  logic [AW-1:0] branch_target = '0;
  logic          branch_valid = 1'b0;
  logic          core_bus_busy = 1'b0;
  logic          rd_valid = 1'b0;
  logic [2:0]    rd_count = 3'd1;
  logic          bus_req, rd_ready, stall;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_rdata, rd_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  assign bus_rdata = bus_req ? {mem_byte(bus_addr + 24'd3), mem_byte(bus_addr + 24'd2),
                                mem_byte(bus_addr + 24'd1), mem_byte(bus_addr)}
                             : 32'hFFFF_FFFF;

  ifetch_queue i_ifetch_queue (
    .clk(clk), .rst_n(rst_n), .reset_vector(reset_vector),
    .branch_valid(branch_valid), .branch_target(branch_target),
    .core_bus_busy(core_bus_busy), .bus_req(bus_req), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .rd_valid(rd_valid), .rd_count(rd_count),
    .rd_ready(rd_ready), .rd_data(rd_data), .stall(stall)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver side of the scoreboard: expected byte stream from an address
  task automatic load_stream(input logic [AW-1:0] a);
    exp_q.delete();
    for (int i = 0; i < 200; i++) exp_q.push_back(mem_byte(a + AW'(i)));
  endtask

  task automatic do_branch(input logic [AW-1:0] t);
    @(posedge clk); #2;
    rd_valid = 1'b0; branch_valid = 1'b1; branch_target = t;
    @(posedge clk); #2;
    branch_valid = 1'b0;
    load_stream(t);
  endtask

  task automatic stream(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      rd_valid = (i % 3) != 2;
      rd_count = 3'((i % 4) + 1);
    end
    @(posedge clk); #2;
    rd_valid = 1'b0;
  endtask

  task automatic expect_idle(input int n, input string req);
    bit quiet = 1'b1;
    repeat (n) begin
      @(negedge clk);
      if (bus_req) quiet = 1'b0;
    end
    chk(quiet, req, 32'(!quiet), 32'd0);
  endtask

  task automatic wait_rise();
    @(negedge clk);
    while (!bus_req) @(negedge clk);
  endtask

  // monitor side of the scoreboard: every transfer is compared byte by byte
  always @(negedge clk) begin
    if (rst_n && rd_valid && rd_ready && !branch_valid) begin
      for (int k = 0; k < int'(rd_count); k++) begin
        logic [7:0] e;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 scoreboard underrun", 32'(rd_data[8*k +: 8]), 32'd0);
        end else begin
          e = exp_q.pop_front();
          chk(rd_data[8*k +: 8] == e, "R5/R9 byte order", 32'(rd_data[8*k +: 8]), 32'(e));
        end
      end
    end
  end

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    load_stream(reset_vector);
    // R1: reset state
    @(negedge clk);
    chk(!bus_req, "R1 bus idle in reset", 32'(bus_req), 32'd0);
    @(posedge clk); #2;
    rst_n = 1'b1; rd_valid = 1'b1; rd_count = 3'd1;
    @(negedge clk);
    chk(!rd_ready, "R1 empty after reset", 32'(rd_ready), 32'd0);
    chk(stall, "R6 stall on empty queue", 32'(stall), 32'd1);
    @(posedge clk); #2;
    rd_valid = 1'b0;
    wait_rise();
    chk(bus_addr == 24'h001000, "R1 first fetch at reset vector", 32'(bus_addr), 32'h001000);
    n = 0;
    while (bus_req) begin n++; @(negedge clk); end
    chk(n == 2, "R2 bus cycle length", 32'(n), 32'd2);

    // R5, R9: mixed request widths on a sequential stream
    stream(60);

    // R3: fill-level boundary
    do_branch(24'h002000);
    repeat (30) @(posedge clk);
    expect_idle(10, "R3 no fetch with 2 free");
    @(posedge clk); #2; rd_valid = 1'b1; rd_count = 3'd1;
    @(posedge clk); #2; rd_valid = 1'b0;
    expect_idle(10, "R3 no fetch with 3 free");
    @(posedge clk); #2; rd_valid = 1'b1; rd_count = 3'd1;
    @(posedge clk); #2; rd_valid = 1'b0;
    n = 0;
    repeat (4) begin @(negedge clk); if (bus_req) n++; end
    chk(n > 0, "R3 fetch once 4 free", 32'(n), 32'd2);
    repeat (6) @(posedge clk);
    @(negedge clk);
    rd_count = 3'd4;
    #1 chk(rd_ready, "R3 full queue readable", 32'(rd_ready), 32'd1);
    stream(20);

    // R8: partial first word for each target offset
    for (int s = 0; s < 4; s++) begin
      logic [AW-1:0] t;
      t = 24'h003000 + AW'(16 * s + s);
      do_branch(t);
      wait_rise();
      while (bus_req) @(negedge clk);
      rd_count = 3'(4 - s);
      #1 chk(rd_ready, "R8 loaded count ready", 32'(rd_ready), 32'd1);
      chk(rd_data[7:0] == mem_byte(t), "R8 target byte first", 32'(rd_data[7:0]), 32'(mem_byte(t)));
      if (s > 0) begin
        rd_count = 3'(5 - s);
        #1 chk(!rd_ready, "R8 no byte below target", 32'(rd_ready), 32'd0);
      end
      stream(15);
    end

    // R4: bus busy before and during a fetch
    @(posedge clk); #2; core_bus_busy = 1'b1;
    do_branch(24'h006001);
    expect_idle(10, "R4 no start while busy");
    @(posedge clk); #2; core_bus_busy = 1'b0;
    wait_rise();
    @(posedge clk); #2; core_bus_busy = 1'b1;
    while (bus_req) @(negedge clk);
    rd_count = 3'd3;
    #1 chk(rd_ready, "R4 in-flight fetch completes", 32'(rd_ready), 32'd1);
    expect_idle(10, "R4 busy holds further fetch");
    @(posedge clk); #2; core_bus_busy = 1'b0;
    stream(20);

    // R7: branch during the last cycle of a fetch
    do_branch(24'h004000);
    wait_rise();
    @(posedge clk); #2;
    branch_valid = 1'b1; branch_target = 24'h005003;
    @(negedge clk);
    chk(bus_req, "R7 fetch was in flight", 32'(bus_req), 32'd1);
    @(posedge clk); #2;
    branch_valid = 1'b0; rd_count = 3'd1;
    load_stream(24'h005003);
    @(negedge clk);
    chk(!bus_req, "R7 fetch cancelled", 32'(bus_req), 32'd0);
    chk(!rd_ready, "R7 queue flushed", 32'(rd_ready), 32'd0);
    stream(40);

    repeat (5) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule